// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Validation

This block turns an asynchronous, idle-high serial line into 8-bit characters. It runs on the system clock and advances only on a sample enable that pulses at sixteen times the bit rate. The line first passes through a two-stage synchronizer. A high-to-low change seen between two sample ticks opens a candidate start bit. The receiver checks the line again near the middle of that bit. A pulse that has already returned high is dropped: it yields no character and no error.

After a start bit is accepted, the data bits are taken once per bit time, least significant bit first, and then the stop bit. The finished character moves from the shift register into a single holding register. The holding register is offered on a valid/ready output. Valid stays high and the data stays stable until the consumer takes it with ready. Back-pressure never stalls the line, because the line cannot wait. When a character completes while the holding register is still occupied, the new character is lost and an overrun flag is raised. Framing and break flags travel with the character they describe.

Top module: `uart_rxv`

## Requirements
- R1: The serial input passes through two synchronizer flops, and the receiver's counters and state advance only on cycles where `samp_tick` is high.
- R2: A start is detected on a tick where the synchronized line is 0 and it was 1 on the previous tick. A line that stays low after a character does not start a new one until it has been seen high.
- R3: Eight ticks after detection, the start bit is sampled once. If it is 1, the receiver returns to idle, and no character, flag or valid change follows.
- R4: The 8 data bits are sampled every 16 ticks after the start-bit sample, least significant bit first. The stop bit is sampled 16 ticks after the last data bit, and the character completes on that tick.
- R5: A completed character is loaded into `rx_data` and `rx_valid` rises. `rx_data` holds while `rx_valid` is high. A cycle with `rx_valid` and `rx_ready` both high removes the character, and `rx_valid` and all three flags return to 0.
- R6: If a character completes while `rx_valid` is high and `rx_ready` is low, `err_overrun` is set and `rx_data`, `err_frame` and `err_break` keep their old values.
- R7: A stop bit sampled as 0 sets `err_frame` together with the loaded character.
- R8: A character whose 8 data bits and stop bit are all 0 sets `err_break` and `err_frame`.
- R9: If a read handshake and a character completion fall in the same cycle, the new character is loaded, `rx_valid` stays 1 and `err_overrun` is 0.
- R10: After reset, `rx_valid`, `err_overrun`, `err_frame` and `err_break` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_tick | input | 1 | Sample enable at 16x the bit rate, one clock wide |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Holding register contents |
| rx_valid | output | 1 | A character is waiting in the holding register |
| rx_ready | input | 1 | Consumer takes the character when `rx_valid` is high |
| err_overrun | output | 1 | A character was lost because the holding register was full |
| err_frame | output | 1 | The held character had a stop bit of 0 |
| err_break | output | 1 | The held character was an all-zero line with a stop bit of 0 |

## Verification
A character completion and a consumer read can fall in the same clock. The holding register must then accept the new character and must not report an overrun. The bench provokes this by leaving one character unread and asserting `rx_ready` for exactly the clock in which its reference model predicts the second stop-bit sample. The outcome is judged against that model on every cycle: `rx_data` must hold the second character, `rx_valid` must stay high and `err_overrun` must be 0.

// File: rtl/uart_rxv_pkg.sv
package uart_rxv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart_rxv_sync.sv
module uart_rxv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rxv_core.sv
module uart_rxv_core
  import uart_rxv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              done_ferr,
  output logic              done_brk
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bcnt;
  logic [DATA_W-1:0] shreg;
  logic              prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      prev_lvl <= 1'b1;
    end else if (tick) begin
      prev_lvl <= line;
      unique case (state)
        ST_IDLE: begin
          if (prev_lvl && !line) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (cnt == HALF_LAST) begin
            cnt  <= '0;
            bcnt <= '0;
            state <= line ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == FULL_LAST) begin
            cnt   <= '0;
            shreg <= {line, shreg[DATA_W-1:1]};
            if (bcnt == BIT_LAST) state <= ST_STOP;
            else                  bcnt  <= bcnt + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == FULL_LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    done      = tick && (state == ST_STOP) && (cnt == FULL_LAST);
    done_data = shreg;
    done_ferr = !line;
    done_brk  = !line && (shreg == '0);
  end

  // R3
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && tick && cnt == HALF_LAST && line) |=> (state == ST_IDLE));

  // R4
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bcnt <= BIT_LAST));
endmodule

// File: rtl/uart_rxv_hold.sv
module uart_rxv_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_ferr,
  input  logic              load_brk,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovr,
  output logic              ferr,
  output logic              brk
);
  logic take;
  assign take = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ovr      <= 1'b0;
      ferr     <= 1'b0;
      brk      <= 1'b0;
    end else if (load && rd_valid && !take) begin
      ovr <= 1'b1;
    end else if (load) begin
      rd_valid <= 1'b1;
      rd_data  <= load_data;
      ferr     <= load_ferr;
      brk      <= load_brk;
      ovr      <= 1'b0;
    end else if (take) begin
      rd_valid <= 1'b0;
      ovr      <= 1'b0;
      ferr     <= 1'b0;
      brk      <= 1'b0;
    end
  end

  // R6
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rd_valid && !rd_ready) |=> (ovr && $stable(rd_data)));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !load) |=> !rd_valid);

  // R5
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(load));

  // R9
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rd_valid && rd_ready) |=> (rd_valid && !ovr));
endmodule

// File: rtl/uart_rxv.sv
module uart_rxv #(
  parameter int DATA_W    = 8,
  parameter int OVS       = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_tick,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              err_break
);
  logic              line_s;
  logic              c_done;
  logic [DATA_W-1:0] c_data;
  logic              c_ferr;
  logic              c_brk;

  uart_rxv_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  uart_rxv_core #(.DATA_W(DATA_W), .OVS(OVS)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (samp_tick),
    .line     (line_s),
    .done     (c_done),
    .done_data(c_data),
    .done_ferr(c_ferr),
    .done_brk (c_brk)
  );

  uart_rxv_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (c_done),
    .load_data(c_data),
    .load_ferr(c_ferr),
    .load_brk (c_brk),
    .rd_ready (rx_ready),
    .rd_valid (rx_valid),
    .rd_data  (rx_data),
    .ovr      (err_overrun),
    .ferr     (err_frame),
    .brk      (err_break)
  );
endmodule

// File: tb/tb_uart_rxv.sv
`timescale 1ns/1ps
module tb_uart_rxv;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, err_overrun, err_frame, err_break;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int phase = 0;
  bit tick_en = 1'b1;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  uart_rxv dut (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .err_overrun(err_overrun), .err_frame(err_frame), .err_break(err_break)
  );

  // sample enable: one clock in four
  always @(negedge clk) begin
    phase     <= (phase + 1) % 4;
    samp_tick <= tick_en && (phase == 2);
  end

  // behavioural reference model
  int m1 = 1, m2 = 1, mprev = 1, mst = 0, mcnt = 0, mbit = 0;
  int msh[$];
  int mvalid = 0, mdata = 0, movr = 0, mfe = 0, mbrk = 0;

  always @(posedge clk) begin
    int   dn, dv, dfe, dbr, rd;
    dn = 0; dv = 0; dfe = 0; dbr = 0;
    if (!rst_n) begin
      m1 = 1; m2 = 1; mprev = 1; mst = 0; mcnt = 0; mbit = 0;
      msh.delete();
      mvalid = 0; mdata = 0; movr = 0; mfe = 0; mbrk = 0;
    end else begin
      if (samp_tick) begin
        if (mst == 0) begin
          if (mprev == 1 && m2 == 0) begin mst = 1; mcnt = 0; end
        end else if (mst == 1) begin
          mcnt++;
          if (mcnt == 8) begin
            mcnt = 0;
            if (m2 == 0) begin mst = 2; msh.delete(); end
            else mst = 0;
          end
        end else if (mst == 2) begin
          mcnt++;
          if (mcnt == 16) begin
            mcnt = 0;
            msh.push_back(m2);
            if (msh.size() == 8) mst = 3;
          end
        end else begin
          mcnt++;
          if (mcnt == 16) begin
            mcnt = 0; mst = 0; dn = 1;
            for (int i = 0; i < 8; i++) dv += msh[i] << i;
            dfe = (m2 == 0);
            dbr = dfe && (dv == 0);
          end
        end
        mprev = m2;
      end
      rd = mvalid && rx_ready;
      if (dn && mvalid && !rd) movr = 1;
      else if (dn) begin
        mvalid = 1; mdata = dv; mfe = dfe; mbrk = dbr; movr = 0;
      end else if (rd) begin
        mvalid = 0; movr = 0; mfe = 0; mbrk = 0;
      end
      m2 = m1; m1 = rxd;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(rx_valid == mvalid[0], "R5 valid", rx_valid, mvalid);
      if (mvalid != 0) chk(rx_data == mdata[7:0], "R4 data", rx_data, mdata);
      chk(err_overrun == movr[0], "R6 overrun", err_overrun, movr);
      chk(err_frame == mfe[0], "R7 frame", err_frame, mfe);
      chk(err_break == mbrk[0], "R8 break", err_break, mbrk);
    end
  end

  localparam int BITCLK = 64;

  task automatic hold_line(input bit v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit stopb);
    hold_line(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) hold_line(d[i], BITCLK);
    hold_line(stopb, BITCLK);
    hold_line(1'b1, 2 * BITCLK);
  endtask

  task automatic take();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(!rx_valid && !err_overrun && !err_frame && !err_break, "R10 reset",
        {rx_valid, err_overrun, err_frame, err_break}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1 R2 plain character
    send(8'hA5, 1'b1);
    chk(rx_valid && rx_data == 8'hA5, "R1 R2 char A5", rx_data, 8'hA5);
    take();
    chk(!rx_valid, "R5 take", rx_valid, 0);

    // R1 no ticks: line low without ticks starts nothing
    tick_en = 1'b0;
    hold_line(1'b0, 200);
    hold_line(1'b1, 20);
    tick_en = 1'b1;
    hold_line(1'b1, BITCLK);
    chk(!rx_valid, "R1 no tick", rx_valid, 0);

    // R3 glitch of a quarter bit
    hold_line(1'b0, 16);
    hold_line(1'b1, 12 * BITCLK);
    chk(!rx_valid && !err_frame, "R3 glitch", rx_valid, 0);

    // R4 LSB-first pattern
    send(8'h01, 1'b1);
    chk(rx_data == 8'h01, "R4 lsb first", rx_data, 8'h01);
    take();

    // R7 framing error
    send(8'h55, 1'b0);
    chk(err_frame && !err_break && rx_data == 8'h55, "R7 frame", err_frame, 1);
    take();

    // R8 break, then R2 no restart while low
    hold_line(1'b0, 14 * BITCLK);
    chk(err_break && err_frame && rx_data == 8'h00, "R8 break", err_break, 1);
    hold_line(1'b1, 2 * BITCLK);
    take();
    chk(!rx_valid, "R2 no restart in break", rx_valid, 0);

    // R6 overrun
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    chk(err_overrun && rx_data == 8'h11, "R6 overrun keep", rx_data, 8'h11);
    take();
    chk(!err_overrun, "R6 overrun clear", err_overrun, 0);

    // R9 read in the completion cycle
    send(8'h33, 1'b1);
    fork
      send(8'h44, 1'b1);
      begin
        forever begin
          @(negedge clk); #1;
          if (mst == 3 && mcnt == 15 && samp_tick) break;
        end
        rx_ready = 1'b1;
        @(negedge clk); #1;
        rx_ready = 1'b0;
      end
    join
    chk(rx_valid && rx_data == 8'h44 && !err_overrun, "R9 same cycle", rx_data, 8'h44);
    take();

    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule